// File: doc/BRIEF.md
# Card Clock Divider and Gate with Deferred Update

This block derives the SD/MMC card clock from the host's base clock. Software programs a divider, a run enable and an idle-gating option into a clock-control register. Those values sit in shadow storage and do not reach the clock generator until software writes the command register with both the go bit and the clock-only bit set. Such a write never produces a bus command. The go bit then reads as 1 until the generator has taken the new settings, and the hardware clears it at that point. Software polls the bit to learn that the update is done.

The generator takes new settings only while the card clock output is low. A high pulse is therefore never shortened. An update can also be told to wait until the data path reports no transfer in progress. To change the frequency safely, software runs three updates in a row: one that turns the enable off, one that zeroes the divider, and one that sets the new divider with the enable on. With a divider N of 1 or more, the card clock is high for N base cycles and then low for N. With N of 0 the base clock passes straight through. When the idle-gating option is on and the card reports idle, the clock stops at a low level.

Top module: `card_clk_gate`

## Requirements
- R1: After reset the clock-control readback is 0 (divider 0, enable off, gating off), the go bit (command register bit 31) reads 0, and the card clock stays low.
- R2: The clock-control register (wr_sel/rd_sel = 0) holds the divider in bits 15:0, the run enable in bit 16 and the idle-gating option in bit 17. Reads return the last value written in those fields, and bits 31:18 read 0.
- R3: A write to the clock-control register alone leaves the card clock unchanged until an update request is accepted.
- R4: A command register write (wr_sel = 1) with bit 31 and bit 21 both set makes bit 31 read 1. Bit 31 returns to 0 once the settings are loaded. A command write that lacks either bit leaves bit 31 at 0 and the clock unchanged.
- R5: With the loaded divider N ≥ 1 and the clock running, the card clock is high for N base cycles and low for N base cycles.
- R6: With the loaded divider 0 and the clock running, the card clock follows the base clock.
- R7: If bit 13 is set in the update request, the load is held while xfer_busy is high and takes place after xfer_busy falls. Without bit 13, xfer_busy does not delay the load.
- R8: New settings are loaded only while the card clock is low. Every high pulse of a divided clock lasts exactly N base cycles, including the pulse in progress when an update is requested.
- R9: With idle-gating loaded and card_idle high, the card clock ends any high half in progress and then stays low. It resumes once card_idle falls.
- R10: With the enable loaded as 0, the card clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 clock-control, 1 command |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 clock-control, 1 command |
| rd_data | output | 32 | Read data for the selected register |
| xfer_busy | input | 1 | A data transfer is in progress |
| card_idle | input | 1 | Card reports idle (used by idle-gating) |
| card_clk | output | 1 | Card clock output |

## Verification
The divided clock is tried with dividers 3, 4, 2 and 1, and with pass-through. Counting high samples over fixed windows separates the correct duty and period from off-by-one counts. An update issued while the divided clock is high shows whether the load waits for the low phase. Running the busy signal with and without the wait bit shows whether the hold is tied to that bit. Toggling card_idle under idle-gating, in both divided and pass-through mode, shows that the clock stops low and restarts cleanly. Single-bit command writes show that the go bit needs both of its qualifiers.

// File: rtl/card_clk_gate.sv
module card_clk_gate #(
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  input  logic        xfer_busy,
  input  logic        card_idle,
  output logic        card_clk
);
  localparam int EN_BIT   = 16;
  localparam int LP_BIT   = 17;
  localparam int GO_BIT   = 31;
  localparam int ONLY_BIT = 21;
  localparam int WAIT_BIT = 13;

  logic [DIV_W-1:0] sh_div, act_div, cnt;
  logic             sh_en, sh_lp, act_en, act_lp;
  logic             pend, wait_q, ph, byp;
  logic [DIV_W:0]   hi_cnt;
  logic             unused_wr;

  wire run     = act_en & ~(act_lp & card_idle);
  wire commit  = pend & ~ph & ~(wait_q & xfer_busy);
  wire upd_req = wr_en & wr_sel & wr_data[GO_BIT] & wr_data[ONLY_BIT];

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_div <= '0;
      sh_en  <= 1'b0;
      sh_lp  <= 1'b0;
    end else if (wr_en && !wr_sel) begin
      sh_div <= wr_data[DIV_W-1:0];
      sh_en  <= wr_data[EN_BIT];
      sh_lp  <= wr_data[LP_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend   <= 1'b0;
      wait_q <= 1'b0;
    end else if (upd_req) begin
      pend   <= 1'b1;
      wait_q <= wr_data[WAIT_BIT];
    end else if (commit) begin
      pend   <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_div <= '0;
      act_en  <= 1'b0;
      act_lp  <= 1'b0;
      cnt     <= '0;
      ph      <= 1'b0;
    end else if (commit) begin
      act_div <= sh_div;
      act_en  <= sh_en;
      act_lp  <= sh_lp;
      cnt     <= '0;
      ph      <= 1'b0;
    end else if (act_div == '0 || (!ph && !run)) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt == act_div - DIV_W'(1)) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) byp <= 1'b0;
    else        byp <= run & (act_div == '0);

  assign card_clk = ph | (clk & byp);

  always_comb begin
    rd_data = '0;
    if (rd_sel) begin
      rd_data[GO_BIT] = pend;
    end else begin
      rd_data[DIV_W-1:0] = sh_div;
      rd_data[EN_BIT]    = sh_en;
      rd_data[LP_BIT]    = sh_lp;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  hi_cnt <= '0;
    else if (ph) hi_cnt <= hi_cnt + 1'b1;
    else         hi_cnt <= '0;

  // R4
  go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(upd_req));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wait_q && xfer_busy) |=> pend);

  // R8
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph) |-> (hi_cnt == {1'b0, act_div}));

  // R8
  load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_div) |-> !$past(ph));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ph) |=> !ph);
endmodule

// File: tb/test_card_clk_gate.sv
module test_card_clk_gate;
  logic        clk, rst_n, wr_en, wr_sel, rd_sel, xfer_busy, card_idle;
  logic [31:0] wr_data, rd_data;
  logic        card_clk;

  card_clk_gate i_card_clk_gate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .xfer_busy(xfer_busy),
    .card_idle(card_idle), .card_clk(card_clk));

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  // behavioural reference
  logic [15:0] s_div, m_div;
  logic        s_en, s_lp, m_en, m_lp, m_pend, m_wait, m_ph, m_byp;
  int          m_half;
  bit          m_run, m_go;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_div = 0; s_en = 0; s_lp = 0; m_div = 0; m_en = 0; m_lp = 0;
      m_pend = 0; m_wait = 0; m_ph = 0; m_half = 0;
    end else begin
      m_run = m_en && !(m_lp && card_idle);
      m_go  = m_pend && !m_ph && !(m_wait && xfer_busy);
      if (m_go) begin
        m_div = s_div; m_en = s_en; m_lp = s_lp; m_ph = 0; m_half = 0;
      end else if (m_div == 0) begin
        m_ph = 0; m_half = 0;
      end else if (!m_ph && !m_run) begin
        m_half = 0;
      end else begin
        m_half++;
        if (m_half == int'(m_div)) begin
          m_ph = !m_ph; m_half = 0;
        end
      end
      if (wr_en && !wr_sel) begin
        s_div = wr_data[15:0]; s_en = wr_data[16]; s_lp = wr_data[17];
      end
      if (wr_en && wr_sel && wr_data[31] && wr_data[21]) begin
        m_pend = 1; m_wait = wr_data[13];
      end else if (m_go) m_pend = 0;
    end
  end

  always @(negedge clk or negedge rst_n)
    if (!rst_n) m_byp = 0;
    else m_byp = (m_div == 0) && m_en && !(m_lp && card_idle);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #5;
      chk(cur_req, "card_clk high half", {31'b0, card_clk}, {31'b0, m_ph | m_byp});
      chk(cur_req, "readback", rd_data,
          rd_sel ? {m_pend, 31'b0} : {14'b0, s_lp, s_en, s_div});
      #10;
      chk(cur_req, "card_clk low half", {31'b0, card_clk}, {31'b0, m_ph});
    end
  end

  task automatic tick;
    @(posedge clk);
    #8;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic upd(input logic [31:0] extra);
    wr(1'b1, 32'h8020_0000 | extra);
  endtask

  task automatic poll(string req);
    rd_sel = 1;
    #1;
    for (int i = 0; i < 40; i++) begin
      if (!rd_data[31]) break;
      tick();
      #1;
    end
    chk(req, "go bit cleared", {31'b0, rd_data[31]}, 32'd0);
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    repeat (n) begin
      tick();
      if (card_clk) hi++;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    xfer_busy = 0; card_idle = 0;
    repeat (3) @(posedge clk);
    #8 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "clkctl after reset", rd_data, 32'd0);
    chk("R1", "card_clk after reset", {31'b0, card_clk}, 32'd0);
    rd_sel = 1; #1;
    chk("R1", "go bit after reset", rd_data, 32'd0);
    rd_sel = 0;

    // R2 field layout, R3 pending
    cur_req = "R2";
    wr(1'b0, 32'h0001_0003); #1;
    chk("R2", "clkctl readback", rd_data, 32'h0001_0003);
    wr(1'b0, 32'hFFFC_0000 | 32'h0001_0003); #1;
    chk("R2", "upper bits read zero", rd_data, 32'h0001_0003);
    cur_req = "R3";
    count_high(6, hi);
    chk("R3", "no clock before update", hi, 0);

    // R4 go bit, R5 divided clock
    cur_req = "R4";
    rd_sel = 1;
    upd(0); #1;
    chk("R4", "go bit set by request", {31'b0, rd_data[31]}, 32'd1);
    tick(); #1;
    chk("R4", "go bit cleared on load", {31'b0, rd_data[31]}, 32'd0);
    cur_req = "R5";
    count_high(12, hi);
    chk("R5", "divide by 3 duty", hi, 6);

    // R4 single qualifiers ignored
    cur_req = "R4";
    wr(1'b0, 32'h0001_0001);
    wr(1'b1, 32'h8000_0000); #1;
    chk("R4", "go alone ignored", {31'b0, rd_data[31]}, 32'd0);
    wr(1'b1, 32'h0020_0000); #1;
    chk("R4", "clock-only alone ignored", {31'b0, rd_data[31]}, 32'd0);
    count_high(12, hi);
    chk("R4", "clock unchanged after ignored writes", hi, 6);

    // R6 ordered switch to pass-through
    cur_req = "R10";
    wr(1'b0, 32'h0000_0003); upd(0); poll("R10");
    count_high(6, hi);
    chk("R10", "enable off holds low", hi, 0);
    cur_req = "R6";
    wr(1'b0, 32'h0000_0000); upd(0); poll("R6");
    wr(1'b0, 32'h0001_0000); upd(0); poll("R6");
    tick(); tick();
    count_high(4, hi);
    chk("R6", "pass-through high samples", hi, 4);

    // R9 idle gating in pass-through
    cur_req = "R9";
    wr(1'b0, 32'h0003_0000); upd(0); poll("R9");
    card_idle = 1;
    count_high(4, hi);
    chk("R9", "pass-through gated while idle", hi, 0);
    card_idle = 0;
    count_high(4, hi);
    chk("R9", "pass-through resumes", hi, 4);

    // R7 wait for transfer
    cur_req = "R7";
    xfer_busy = 1;
    wr(1'b0, 32'h0001_0002);
    upd(32'h0000_2000);
    repeat (10) tick();
    #1;
    chk("R7", "load held while busy", {31'b0, rd_data[31]}, 32'd1);
    xfer_busy = 0;
    poll("R7");
    xfer_busy = 1;
    wr(1'b0, 32'h0001_0004);
    upd(0);
    repeat (3) tick();
    #1;
    chk("R7", "busy ignored without wait bit", {31'b0, rd_data[31]}, 32'd0);
    xfer_busy = 0;

    // R8 update requested during a high phase
    cur_req = "R8";
    for (int i = 0; i < 20; i++) begin
      if (card_clk) break;
      tick();
    end
    chk("R8", "found high phase", {31'b0, card_clk}, 32'd1);
    wr(1'b0, 32'h0001_0001);
    upd(0);
    poll("R8");
    count_high(8, hi);
    chk("R8", "divide by 1 after safe load", hi, 4);

    // R9 idle gating in divided mode
    cur_req = "R9";
    wr(1'b0, 32'h0003_0002); upd(0); poll("R9");
    card_idle = 1;
    count_high(4, hi);
    count_high(4, hi);
    chk("R9", "divided gated while idle", hi, 0);
    card_idle = 0;
    count_high(8, hi);
    chk("R5", "divide by 2 after idle", hi, 4);

    // R10 disable divided
    cur_req = "R10";
    wr(1'b0, 32'h0000_0002); upd(0); poll("R10");
    count_high(6, hi);
    chk("R10", "divided disabled", hi, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule